// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a half-duplex SPI master for serial flash devices. It runs exactly one command each time software writes the command register. The command word controls the whole transfer: an opcode, a 0 to 3 byte address, 0 to 15 dummy byte times and 0 to 4 data bytes, in either the write or the read direction. Before issuing a command, software loads the address register and the 32-bit data register. It then polls the status register until the pending flag drops, and reads any received bytes back from the data register.

Chip select can be held across commands, so one long flash transaction can be built from several commands. The opcode is sent only when the device goes from deselected to selected. A command issued while chip select is still held skips the opcode and continues with its own address, dummy and data phases. Serial clock edges are paced by a `half_tick` strobe that comes from an external timing block. Each strobe advances the serial clock by one half period.

Top module: `sflash_cmd_seq`

## Requirements
- R1: The register bus selects one of four registers with `reg_sel`: 0 is command, 1 is address, 2 is data and 3 is status. The command word holds these fields: opcode in bits 7:0, write direction in bit 8 (1 = write), data byte count in bits 11:9 (values above 4 act as 4), keep-selected in bit 15, dummy byte count in bits 19:16, address byte count in bits 22:20 (values above 3 act as 3) and chip select index in bits 26:24. A command write while the block is idle starts the command, and the opcode is sent first when the device was deselected. Address and data writes are ignored while a command is pending.
- R2: After the opcode, the block sends the address bytes, taking the low 8×count bits of the address register, most significant byte first. Every byte goes out on the wire most significant bit first.
- R3: Dummy byte times follow the address. During them the data output is driven to 0.
- R4: On a write, data bytes follow the dummy phase, starting with bits 7:0 of the data register. The data register is not changed by a write command.
- R5: On a read, the n-th received byte is stored in bits 8n+7:8n of the data register. Bytes at or beyond the count keep their previous value, and the data output is driven to 0 while reading.
- R6: The serial clock follows SPI mode 3. It idles high, falls to present a new output bit and rises to sample input. Each `half_tick` advances it by one half period.
- R7: While selected, exactly one `cs_n` bit (the one given by the index) is low. With keep-selected set, chip select stays asserted after the command. With it clear, chip select is released when the command finishes. Outside a command, `cs_n` does not change.
- R8: A command issued while chip select is held keeps the original chip select index and sends no opcode.
- R9: A command issued while selected, with zero address, dummy and data counts and keep-selected clear, produces no clock edges and only releases chip select.
- R10: Status bit 22 (pending) is high from the accepting edge until the command ends. A one-cycle `done` pulse occurs in the same cycle in which pending clears.
- R11: A command write while a command is pending sets status bit 29 (error) and leaves the running command unchanged. Writing 1 to status bit 29 clears it.
- R12: After reset, every `cs_n` bit is high, `sck` is high, `done` is low and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| half_tick | input | 1 | Serial clock half-period strobe |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | NCS | Active-low chip selects |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| done | output | 1 | One-cycle command completion pulse |

## Verification
A sweep from the deselected state covers every address length from 0 to 3, dummy lengths from 0 to 2, data counts from 0 to 4 and both directions, with several tick spacings. It separates the phase boundaries and the byte ordering of each phase, and shows that a read leaves the bytes it did not receive untouched. A held-select sequence is then run: an address-only command, a read with a different select index, a write, and a zero-length release. It distinguishes opcode skipping, select holding and release without any clock edges. A command written during a running one shows that the error is flagged without disturbing the transfer, and the spacing of clock rises confirms the half-tick pacing.

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_sel,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           half_tick,
  output logic           sck,
  output logic [NCS-1:0] cs_n,
  output logic           mosi,
  input  logic           miso,
  output logic           done
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} st_t;

  st_t         st_q;
  logic [31:0] cmd_q, addr_q, data_q;
  logic        pend_q, err_q, sel_q, done_q, sck_q, mosi_q, nop_q;
  logic [2:0]  cs_idx_q, bit_q;
  logic [4:0]  byte_q, nbytes_q;

  logic [1:0] f_alen;
  logic [2:0] f_dlen;
  logic [3:0] f_dum;
  logic       f_keep, f_wr;

  assign f_alen = (cmd_q[22:20] > 3'd3) ? 2'd3 : cmd_q[21:20];
  assign f_dlen = (cmd_q[11:9] > 3'd4) ? 3'd4 : cmd_q[11:9];
  assign f_dum  = cmd_q[19:16];
  assign f_keep = cmd_q[15];
  assign f_wr   = cmd_q[8];

  logic [4:0] tot_c, off_a, off_d, off_x, kw, jw;
  logic [1:0] ai;
  logic       is_op, is_addr, is_data;
  logic [7:0] cur_byte;

  assign tot_c   = {4'b0, ~sel_q} + {3'b0, f_alen} + {1'b0, f_dum} + {2'b0, f_dlen};
  assign off_a   = {4'b0, nop_q};
  assign off_d   = off_a + {3'b0, f_alen};
  assign off_x   = off_d + {1'b0, f_dum};
  assign kw      = byte_q - off_a;
  assign jw      = byte_q - off_x;
  assign ai      = f_alen - 2'd1 - kw[1:0];
  assign is_op   = nop_q && (byte_q == 5'd0);
  assign is_addr = !is_op && (byte_q < off_d);
  assign is_data = byte_q >= off_x;

  always_comb begin
    if (is_op)                cur_byte = cmd_q[7:0];
    else if (is_addr)         cur_byte = addr_q[{ai, 3'b000} +: 8];
    else if (is_data && f_wr) cur_byte = data_q[{jw[1:0], 3'b000} +: 8];
    else                      cur_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cmd_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      sel_q    <= 1'b0;
      done_q   <= 1'b0;
      sck_q    <= 1'b1;
      mosi_q   <= 1'b0;
      nop_q    <= 1'b0;
      cs_idx_q <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      nbytes_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          2'd0: if (pend_q) err_q <= 1'b1;
                else begin
                  cmd_q  <= reg_wdata;
                  pend_q <= 1'b1;
                  st_q   <= S_LOAD;
                end
          2'd1: if (!pend_q) addr_q <= reg_wdata;
          2'd2: if (!pend_q) data_q <= reg_wdata;
          default: if (reg_wdata[29]) err_q <= 1'b0;
        endcase
      end
      case (st_q)
        S_LOAD: begin
          nop_q    <= ~sel_q;
          nbytes_q <= tot_c;
          byte_q   <= '0;
          bit_q    <= '0;
          if (tot_c == 5'd0) st_q <= S_FIN;
          else begin
            st_q <= S_RUN;
            if (!sel_q) begin
              sel_q    <= 1'b1;
              cs_idx_q <= cmd_q[26:24];
            end
          end
        end
        S_RUN: if (half_tick) begin
          if (sck_q) begin
            sck_q  <= 1'b0;
            mosi_q <= cur_byte[~bit_q];
          end else begin
            sck_q <= 1'b1;
            if (is_data && !f_wr) data_q[{jw[1:0], ~bit_q}] <= miso;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              byte_q <= byte_q + 5'd1;
              if (byte_q == nbytes_q - 5'd1) st_q <= S_FIN;
            end
          end
        end
        S_FIN: begin
          if (!f_keep) sel_q <= 1'b0;
          pend_q <= 1'b0;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = cmd_q;
      2'd1:    reg_rdata = addr_q;
      2'd2:    reg_rdata = data_q;
      default: begin
        reg_rdata     = '0;
        reg_rdata[29] = err_q;
        reg_rdata[22] = pend_q;
      end
    endcase
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign done = done_q;
  assign cs_n = sel_q ? ~(NCS'(1) << cs_idx_q) : '1;

  wire unused_ok = ^{cmd_q[31:27], cmd_q[23], cmd_q[14:12], addr_q[31:24], kw[4:2], jw[4:2]};

endmodule

module sflash_cmd_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           done,
  input logic           pend,
  input logic           err,
  input logic           reg_we,
  input logic [1:0]     reg_sel
);

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n) |-> sck);

  // R7
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !pend |=> $stable(cs_n));

  // R10
  done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!pend && $past(pend)));

  // R10
  pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(pend) |-> done);

  // R11
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0 && pend) |=> err);

  // R6
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n) !pend |=> sck);

endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .done(done),
  .pend(pend_q), .err(err_q), .reg_we(reg_we), .reg_sel(reg_sel)
);

// File: tb/sflash_cmd_seq_test.sv
`timescale 1ns/1ps
module sflash_cmd_seq_test;

  logic        clk = 0, rst_n = 0, reg_we = 0, half_tick = 1, miso = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  wire  [31:0] reg_rdata;
  wire  [3:0]  cs_n;
  wire         sck, mosi, done;

  sflash_cmd_seq #(.NCS(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_tick(half_tick),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .done(done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int tdiv = 1, tc = 0;

  always @(negedge clk) begin
    tc = (tc + 1 >= tdiv) ? 0 : tc + 1;
    half_tick = (tc == 0);
  end

  logic [7:0] lg [0:2047];
  int  tot_bits = 0, base_b = 0;
  logic [3:0] sel_csn = 4'hF;
  time t_prev = 0, t_per = 0;
  wire csn_all = &cs_n;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 29 + 91) & 255);
  endfunction

  always @(posedge sck) if (!csn_all) begin
    lg[tot_bits / 8][7 - tot_bits % 8] = mosi;
    tot_bits++;
    t_per  = $time - t_prev;
    t_prev = $time;
  end

  always @(negedge csn_all) begin
    base_b  = tot_bits / 8;
    sel_csn = cs_n;
  end

  always @(negedge sck) if (!csn_all) begin
    int k;
    k = tot_bits - base_b * 8;
    miso = pat(k / 8)[7 - k % 8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done;
    do begin
      @(posedge clk); #1;
    end while (!done);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input logic w, input int dl,
                                     input logic keep, input int dm, input int al, input int cs);
    logic [31:0] c;
    c = 0;
    c[7:0] = op; c[8] = w; c[11:9] = 3'(dl); c[15] = keep;
    c[19:16] = 4'(dm); c[22:20] = 3'(al); c[26:24] = 3'(cs);
    return c;
  endfunction

  initial begin
    #300000;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, ad, dt, ex;
    int idx, t0, b0;
    logic [7:0] op;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 cs_n", {28'b0, cs_n}, 32'hF);
    check("R12 sck", {31'b0, sck}, 32'h1);
    check("R12 done", {31'b0, done}, 32'h0);
    rd(3, v); check("R12 status", v, 32'h0);

    idx = 0;
    for (int al = 0; al < 4; al++)
      for (int dm = 0; dm < 3; dm++)
        for (int dl = 0; dl < 5; dl++)
          for (int w = 0; w < 2; w++) begin
            tdiv = idx % 3 + 1;
            op = 8'(8'h10 + idx);
            ad = 32'hA1B2C3D4 ^ (idx * 32'h00010307);
            dt = 32'h13579BDF + idx * 32'h01030507;
            wr(1, ad); wr(2, dt);
            t0 = tot_bits;
            wr(0, mk(op, w[0], dl, 1'b0, dm, al, idx % 4));
            wait_done;
            rd(3, v); check("R10 pending cleared", v, 32'h0);
            check("R7 released", {28'b0, cs_n}, 32'hF);
            check("R7 index", {28'b0, sel_csn}, {28'b0, ~(4'b1 << (idx % 4))});
            check("R1 bit count", tot_bits - t0, 8 * (1 + al + dm + dl));
            b0 = t0 / 8;
            check("R1 opcode", {24'b0, lg[b0]}, {24'b0, op});
            for (int i = 0; i < al; i++)
              check("R2 address byte", {24'b0, lg[b0 + 1 + i]}, {24'b0, ad[8 * (al - 1 - i) +: 8]});
            for (int i = 0; i < dm; i++)
              check("R3 dummy byte", {24'b0, lg[b0 + 1 + al + i]}, 32'h0);
            for (int i = 0; i < dl; i++)
              if (w == 1) check("R4 write byte", {24'b0, lg[b0 + 1 + al + dm + i]}, {24'b0, dt[8 * i +: 8]});
              else        check("R5 read mosi", {24'b0, lg[b0 + 1 + al + dm + i]}, 32'h0);
            ex = dt;
            if (w == 0)
              for (int i = 0; i < dl; i++) ex[8 * i +: 8] = pat(1 + al + dm + i);
            rd(2, v);
            check(w == 1 ? "R4 data kept" : "R5 read data", v, ex);
            idx++;
          end

    // R8 R9 held-select sequence
    tdiv = 2;
    wr(1, 32'h00123456);
    t0 = tot_bits;
    wr(0, mk(8'h0B, 1'b0, 0, 1'b1, 1, 3, 2));
    wait_done;
    check("R7 kept", {28'b0, cs_n}, 32'hB);
    b0 = t0 / 8;
    check("R2 held addr0", {24'b0, lg[b0 + 1]}, 32'h12);
    check("R2 held addr2", {24'b0, lg[b0 + 3]}, 32'h56);
    check("R3 held dummy", {24'b0, lg[b0 + 4]}, 32'h0);
    t0 = tot_bits;
    wr(2, 32'hFFFFFFFF);
    wr(0, mk(8'h77, 1'b0, 4, 1'b1, 0, 0, 0));
    wait_done;
    check("R8 no opcode", tot_bits - t0, 32);
    check("R8 index kept", {28'b0, cs_n}, 32'hB);
    rd(2, v);
    check("R8 read data", v, {pat(8), pat(7), pat(6), pat(5)});
    t0 = tot_bits;
    wr(2, 32'h0000BEEF);
    wr(0, mk(8'h55, 1'b1, 2, 1'b1, 0, 0, 1));
    wait_done;
    check("R8 write bits", tot_bits - t0, 16);
    check("R8 write byte0", {24'b0, lg[t0 / 8]}, 32'hEF);
    check("R8 write byte1", {24'b0, lg[t0 / 8 + 1]}, 32'hBE);
    t0 = tot_bits;
    wr(0, mk(8'h99, 1'b0, 0, 1'b0, 0, 0, 3));
    wait_done;
    check("R9 no clocks", tot_bits - t0, 0);
    check("R9 released", {28'b0, cs_n}, 32'hF);

    // R11 busy write, R6 pacing
    tdiv = 3;
    wr(2, 32'h11223344);
    t0 = tot_bits;
    wr(0, mk(8'h02, 1'b1, 4, 1'b0, 0, 0, 1));
    repeat (2) @(negedge clk);
    wr(0, mk(8'h9F, 1'b0, 3, 1'b0, 2, 3, 0));
    rd(3, v);
    check("R11 error set", v, 32'h20400000);
    wait_done;
    check("R11 bits", tot_bits - t0, 40);
    check("R11 op", {24'b0, lg[t0 / 8]}, 32'h02);
    check("R11 data0", {24'b0, lg[t0 / 8 + 1]}, 32'h44);
    check("R11 data3", {24'b0, lg[t0 / 8 + 4]}, 32'h11);
    check("R6 period", 32'(t_per), 32'd24);
    repeat (30) @(negedge clk);
    check("R11 no second cmd", tot_bits - t0, 40);
    rd(3, v); check("R11 error held", v, 32'h20000000);
    wr(3, 32'h20000000);
    rd(3, v); check("R11 error cleared", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule